// File: doc/BRIEF.md
# SRAM Failure-Counting Self-Test Controller

This controller measures functional read failures in a small SRAM array. An initialization step writes one data pattern into every row at once. The controller then walks a single active word-line through the rows and compares each bit read back with the pattern. It keeps per-column failure counts and finally streams those counts out on one serial pin. The array sits outside the block and connects through a word-line vector, a write enable, write data and read data.

Test control uses three inputs besides the clock and the asynchronous reset. `feed` forces every word-line on and writes the pattern into all rows. `mode` selects the pattern. `arm` holds the controller cleared, and its falling edge launches the walk. Each row is sampled twice. The first sample comes on the first cycle the row is on, which is the at-speed read. The second comes after the row has been held for `SLOW_CYC` more cycles, which is the relaxed read. Each column therefore gets an at-speed count and a true-failure count, and a cell that fails only the at-speed read is an access failure rather than a read failure. `flag` reports that at least one true failure has been seen.

Top module: `sram_fail_tester`

## Requirements
- R1: While `feed` is 1, every word-line is 1, `we` is 1 and every bit of `wdata` equals `mode`.
- R2: When `arm` was 1 in the previous cycle and is 0 now, the next clock edge turns on word-line 0 alone. While `feed` is 0, at most one word-line is on.
- R3: The single active word-line stays on for `SLOW_CYC`+1 cycles per row and visits rows from index 0 upward. After the last row, all word-lines are off.
- R4: On the first cycle of each row, every column whose read bit differs from the expected pattern adds one to that column's at-speed count.
- R5: On the last cycle of each row, every column whose read bit differs from the expected pattern adds one to that column's true-failure count.
- R6: Both counts are 6 bits wide and stop at 63 instead of wrapping.
- R7: `flag` rises at the clock edge that records the first true failure and stays 1 until `arm` is raised.
- R8: One cycle after the walk ends, `tout` carries COLS×12 bits, one per clock. The order is column 0 at-speed count, column 0 true-failure count, then column 1 and upward, each count MSB first. At all other times `tout` is 0.
- R9: The expected pattern is the last value of `mode` seen while `feed` was 1. Changes of `mode` while `feed` is 0 have no effect on the counts.
- R10: A clock edge with `arm` at 1 clears both counts and `flag`, stops any walk or dump and turns off all word-lines unless `feed` is 1.
- R11: After reset, with `arm` and `feed` at 0, all word-lines, `flag` and `tout` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| arm | input | 1 | Hold-clear control; its falling edge starts the walk |
| feed | input | 1 | Turns on all rows and writes the pattern |
| mode | input | 1 | Pattern bit written and expected |
| rdata | input | COLS | Read data from the active row |
| wl | output | ROWS | Word-lines to the array |
| we | output | 1 | Array write enable |
| wdata | output | COLS | Array write data |
| flag | output | 1 | At least one true failure seen |
| tout | output | 1 | Serial count output |

## Verification
The array model starts each run with random contents, so a feed step that missed any row would show up as failures in a fault-free run. Stuck-at cells of both polarities are tested under both patterns. A design that latched `mode` outside the feed window, or compared against the wrong polarity, would count the wrong set of cells. Cells that return wrong data only on the first cycle of their row must show up in the at-speed count alone. Swapping the two sample points, or sampling both on the same cycle, would move or duplicate them. The remaining runs cover columns with 62, 63 and 72 failing rows, which a wrapping counter gets wrong. They also cover the cycle on which `flag` rises and an abort in the middle of a walk.

// File: rtl/sram_fail_tester.sv
module sram_fail_tester #(
  parameter int ROWS     = 256,
  parameter int COLS     = 4,
  parameter int CNT_W    = 6,
  parameter int SLOW_CYC = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            arm,
  input  logic            feed,
  input  logic            mode,
  input  logic [COLS-1:0] rdata,
  output logic [ROWS-1:0] wl,
  output logic            we,
  output logic [COLS-1:0] wdata,
  output logic            flag,
  output logic            tout
);
  localparam int SLOT_W   = $clog2(SLOW_CYC + 1);
  localparam int DUMP_LEN = COLS * 2 * CNT_W;
  localparam int DCNT_W   = $clog2(DUMP_LEN);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef enum logic [1:0] {S_IDLE, S_WALK, S_LATCH, S_SHIFT} state_t;

  state_t              st;
  logic                arm_q;
  logic                pat;
  logic [ROWS-1:0]     tok;
  logic [SLOT_W-1:0]   slot;
  logic [DCNT_W-1:0]   dcnt;
  logic [DUMP_LEN-1:0] sr;
  logic [DUMP_LEN-1:0] lat_vec;
  logic [COLS-1:0]     miss;
  logic                start, fast_smp, slow_smp, dumping;

  assign start    = arm_q & ~arm;
  assign fast_smp = (st == S_WALK) && (slot == '0);
  assign slow_smp = (st == S_WALK) && (slot == SLOT_W'(SLOW_CYC));
  assign miss     = rdata ^ {COLS{pat}};
  assign dumping  = (st == S_SHIFT);

  assign wl    = feed ? '1 : tok;
  assign we    = feed;
  assign wdata = {COLS{mode}};
  assign tout  = dumping & sr[DUMP_LEN-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_q <= 1'b0;
      pat   <= 1'b0;
    end else begin
      arm_q <= arm;
      if (feed) pat <= mode;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      tok  <= '0;
      slot <= '0;
      dcnt <= '0;
      sr   <= '0;
    end else if (arm) begin
      st   <= S_IDLE;
      tok  <= '0;
      slot <= '0;
      dcnt <= '0;
    end else if (start) begin
      st   <= S_WALK;
      tok  <= ROWS'(1);
      slot <= '0;
    end else begin
      case (st)
        S_WALK: begin
          if (slot == SLOT_W'(SLOW_CYC)) begin
            slot <= '0;
            tok  <= tok << 1;
            if (tok[ROWS-1]) st <= S_LATCH;
          end else begin
            slot <= slot + SLOT_W'(1);
          end
        end
        S_LATCH: begin
          sr   <= lat_vec;
          dcnt <= '0;
          st   <= S_SHIFT;
        end
        S_SHIFT: begin
          sr <= sr << 1;
          if (dcnt == DCNT_W'(DUMP_LEN - 1)) st <= S_IDLE;
          else dcnt <= dcnt + DCNT_W'(1);
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  for (genvar c = 0; c < COLS; c++) begin : col_g
    logic [CNT_W-1:0] fc, sc;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fc <= '0;
        sc <= '0;
      end else if (arm) begin
        fc <= '0;
        sc <= '0;
      end else begin
        if (fast_smp && miss[c] && fc != CNT_MAX) fc <= fc + CNT_W'(1);
        if (slow_smp && miss[c] && sc != CNT_MAX) sc <= sc + CNT_W'(1);
      end
    end

    assign lat_vec[DUMP_LEN-1-(2*c)*CNT_W   -: CNT_W] = fc;
    assign lat_vec[DUMP_LEN-1-(2*c+1)*CNT_W -: CNT_W] = sc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 flag <= 1'b0;
    else if (arm)               flag <= 1'b0;
    else if (slow_smp && |miss) flag <= 1'b1;
  end
endmodule

// File: rtl/sram_fail_tester_chk.sv
module sram_fail_tester_chk #(
  parameter int ROWS = 256,
  parameter int COLS = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            arm,
  input logic            feed,
  input logic            mode,
  input logic [ROWS-1:0] wl,
  input logic            we,
  input logic [COLS-1:0] wdata,
  input logic            flag,
  input logic            tout,
  input logic            dumping
);
  logic arm_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_d <= 1'b0;
    else        arm_d <= arm;
  end

  // R1
  feed_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    feed |-> ((&wl) && we && (wdata == {COLS{mode}})));

  // R2
  start_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm_d && !arm && !feed) |=> (feed || wl == ROWS'(1)));

  // R2
  one_row_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !feed |-> $onehot0(wl));

  // R7
  flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !arm) |=> flag);

  // R8
  tout_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dumping |-> !tout);

  // R10
  arm_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (!flag && !dumping && (feed || wl == '0)));
endmodule

bind sram_fail_tester sram_fail_tester_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .arm(arm), .feed(feed), .mode(mode), .wl(wl),
  .we(we), .wdata(wdata), .flag(flag), .tout(tout), .dumping(dumping)
);

// File: tb/test_sram_fail_tester.sv
`timescale 1ns/1ps
module test_sram_fail_tester;
  localparam int ROWS = 72;
  localparam int COLS = 4;
  localparam int SLOW = 2;
  localparam int SLOT = SLOW + 1;
  localparam int NB   = COLS * 12;

  logic clk = 1'b0, rst_n = 1'b0, arm = 1'b0, feed = 1'b0, mode = 1'b0;
  logic [COLS-1:0] rdata, wdata;
  logic [ROWS-1:0] wl, wl_prev;
  logic we, flag, tout, scramble = 1'b0;
  logic [COLS-1:0] mem [ROWS];
  logic [COLS-1:0] sa0 [ROWS];
  logic [COLS-1:0] sa1 [ROWS];
  logic [COLS-1:0] slw [ROWS];
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  sram_fail_tester #(.ROWS(ROWS), .COLS(COLS), .CNT_W(6), .SLOW_CYC(SLOW)) i_sram_fail_tester (
    .clk(clk), .rst_n(rst_n), .arm(arm), .feed(feed), .mode(mode), .rdata(rdata),
    .wl(wl), .we(we), .wdata(wdata), .flag(flag), .tout(tout));

  always @(posedge clk) begin
    wl_prev <= wl;
    for (int r = 0; r < ROWS; r++) begin
      if (scramble) mem[r] <= COLS'($urandom);
      else if (we && wl[r]) mem[r] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int r = 0; r < ROWS; r++)
      if (wl[r])
        for (int c = 0; c < COLS; c++)
          rdata[c] = sa1[r][c] ? 1'b1 : sa0[r][c] ? 1'b0 :
                     (slw[r][c] && !wl_prev[r]) ? ~mem[r][c] : mem[r][c];
  end

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic bit tfail(int r, int c, logic p);
    return p ? (sa0[r][c] && !sa1[r][c]) : sa1[r][c];
  endfunction

  function automatic bit ffail(int r, int c, logic p);
    return tfail(r, c, p) || (slw[r][c] && !sa0[r][c] && !sa1[r][c]);
  endfunction

  function automatic bit row_fails(int r, logic p);
    for (int c = 0; c < COLS; c++) if (tfail(r, c, p)) return 1'b1;
    return 1'b0;
  endfunction

  task automatic clear_faults();
    for (int r = 0; r < ROWS; r++) begin
      sa0[r] = '0; sa1[r] = '0; slw[r] = '0;
    end
  endtask

  task automatic init_array(logic m);
    @(negedge clk) scramble = 1'b1;
    @(negedge clk) scramble = 1'b0; arm = 1'b1; feed = 1'b1; mode = ~m;
    @(negedge clk);
    chk(wl == '1 && we && wdata == {COLS{~m}}, "R1", "feed drive", wdata, {COLS{~m}});
    mode = m;
    @(negedge clk) feed = 1'b0; mode = ~m;
  endtask

  task automatic run_test(logic m, string tag);
    bit walk_ok = 1'b1, flag_ok = 1'b1, flag_exp = 1'b0;
    logic [ROWS-1:0] bad_wl = '0, exp_wl;
    logic [NB-1:0] bits;
    init_array(m);
    @(negedge clk) arm = 1'b0;
    for (int k = 0; k <= SLOT * ROWS; k++) begin
      @(negedge clk);
      if (k >= SLOT && k % SLOT == 0 && row_fails(k / SLOT - 1, m)) flag_exp = 1'b1;
      exp_wl = (k < SLOT * ROWS) ? (ROWS'(1) << (k / SLOT)) : '0;
      if (wl != exp_wl && walk_ok) begin walk_ok = 1'b0; bad_wl = wl; end
      if (flag != flag_exp) flag_ok = 1'b0;
      if (k == 0) chk(wl == ROWS'(1), "R2", {tag, " first row after arm falls"}, wl, 1);
    end
    chk(walk_ok, "R3", {tag, " word-line walk"}, bad_wl, 0);
    chk(flag_ok, "R7", {tag, " flag timing"}, flag, flag_exp);
    for (int j = 0; j < NB; j++) begin
      @(negedge clk);
      bits[NB-1-j] = tout;
    end
    @(negedge clk);
    chk(tout == 1'b0, "R8", {tag, " tout idle after dump"}, tout, 0);
    chk(flag == flag_exp, "R7", {tag, " flag held"}, flag, flag_exp);
    for (int c = 0; c < COLS; c++) begin
      int fe = 0, se = 0;
      for (int r = 0; r < ROWS; r++) begin
        fe += ffail(r, c, m);
        se += tfail(r, c, m);
      end
      if (fe > 63) fe = 63;
      if (se > 63) se = 63;
      chk(bits[NB-1-(2*c)*6 -: 6] == 6'(fe), "R4",
          $sformatf("%s R8 col%0d at-speed count", tag, c), bits[NB-1-(2*c)*6 -: 6], fe);
      chk(bits[NB-1-(2*c+1)*6 -: 6] == 6'(se), "R5",
          $sformatf("%s R8 col%0d true count", tag, c), bits[NB-1-(2*c+1)*6 -: 6], se);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R3 watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    clear_faults();
    repeat (3) @(negedge clk);
    // R11
    chk(wl == '0 && flag == 1'b0 && tout == 1'b0, "R11", "reset state", {wl, flag, tout}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(wl == '0 && flag == 1'b0 && tout == 1'b0, "R11", "after reset release", {wl, flag, tout}, 0);

    run_test(1'b0, "R9 clean p0");
    run_test(1'b1, "R9 clean p1");

    sa1[3][0] = 1'b1; sa1[10][0] = 1'b1; sa1[10][2] = 1'b1; sa1[71][3] = 1'b1; sa1[0][1] = 1'b1;
    run_test(1'b0, "sa1 p0");
    run_test(1'b1, "R9 sa1 p1");

    clear_faults();
    slw[5][1] = 1'b1; slw[6][1] = 1'b1; slw[40][3] = 1'b1; slw[71][0] = 1'b1;
    run_test(1'b1, "slow cells");

    clear_faults();
    for (int r = 0; r < ROWS; r++) sa0[r][0] = 1'b1;
    for (int r = 0; r < 63; r++) sa0[r][1] = 1'b1;
    for (int r = 0; r < 62; r++) sa0[r][2] = 1'b1;
    slw[70][2] = 1'b1;
    run_test(1'b1, "R6 saturation");

    for (int s = 0; s < 6; s++) begin
      for (int r = 0; r < ROWS; r++) begin
        sa0[r] = COLS'($urandom & $urandom & $urandom);
        sa1[r] = COLS'($urandom & $urandom & $urandom);
        slw[r] = COLS'($urandom & $urandom);
      end
      run_test(1'(s), $sformatf("sweep%0d", s));
    end

    // R10 abort in the middle of a walk
    clear_faults();
    sa1[0][2] = 1'b1;
    init_array(1'b0);
    @(negedge clk) arm = 1'b0;
    repeat (20) @(negedge clk);
    chk(flag == 1'b1, "R7", "flag before abort", flag, 1);
    arm = 1'b1;
    @(negedge clk);
    chk(wl == '0 && flag == 1'b0 && tout == 1'b0, "R10", "abort clears", {wl, flag, tout}, 0);
    repeat (SLOT * ROWS + NB) @(negedge clk);
    chk(tout == 1'b0 && wl == '0, "R10", "no dump after abort", {wl, tout}, 0);
    arm = 1'b0;
    @(negedge clk);
    chk(wl == ROWS'(1), "R2", "restart after abort", wl, 1);
    @(negedge clk) arm = 1'b1;
    @(negedge clk) arm = 1'b0;
    clear_faults();
    run_test(1'b0, "after abort");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule